// File: doc/BRIEF.md
# Start-Only Watchdog Timer

This block is a watchdog down counter. Its reload period is fixed when the block is built. After reset the counter holds its preload value and does not count. Software arms it with one write to the control register, and from then on nothing can halt it. To keep the watchdog from expiring, software writes to either of the two period addresses. The value written is ignored; the write only puts the count back to its fixed starting value. If the count is allowed to reach zero, the block raises a single-clock, registered reset request for the system reset logic. It also sets a sticky timeout flag and reloads, so the next period starts straight away.

Access is through a 16-bit register bus: a write strobe, a 3-bit address, write data, and read data that is combinational on the address. An optional snapshot pair can latch the running count coherently, so software can read how much time is left.

Top module: `wdt_start_only`

## Requirements
- R1: While reset is held and afterwards until armed, `rst_req` is 0, status reads 0 and the counter holds `RELOAD_CLOCKS-1`. A snapshot taken before arming therefore reads `RELOAD_CLOCKS-1`, and the snapshot registers reset to 0.
- R2: A write to address 1 with data bit 0 set arms the counter, and status bit 1 (running) reads 1 from the next cycle on. A write to address 1 with bit 0 clear does not arm it. Address 1 reads 0.
- R3: Once running, a write to address 1 with data bit 1 (the halt request) set does not stop or delay the count.
- R4: Counting from the clock edge that takes the arming write, the reset request goes high after `RELOAD_CLOCKS` edges. After that it repeats every `RELOAD_CLOCKS` edges, because the counter reloads on zero.
- R5: `rst_req` comes from a register and is high for exactly one clock per expiry.
- R6: A write to address 2 or 3, whatever the data, reloads the counter to `RELOAD_CLOCKS-1` without stopping it. The next request then follows `RELOAD_CLOCKS` edges after that write's edge.
- R7: Addresses 2 and 3 read back the low and high 16 bits of `RELOAD_CLOCKS-1`, and writes to them do not change what is read.
- R8: If a restart write lands in the cycle where the running count is zero, the restart wins: no reset request is issued and the timeout flag stays clear.
- R9: Status bit 0 (timeout) sets on every expiry and holds until any write to address 0. Such a write leaves bit 1 (running) unchanged.
- R10: A write to address 4 or 5 captures the whole counter in one step. Addresses 4 and 5 read its low and high halves, and the capture does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counter |
| rst | input | 1 | Synchronous active-high reset |
| wr | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| rst_req | output | 1 | One-clock registered reset request on expiry |

## Verification
Expiry timing is measured in three situations: from the arming edge, from a restart write made partway through a period, and from the free reload that follows a previous expiry. Each gives a different expected edge count, so an off-by-one in the reload value or in the request register shows up in at least one of them. A restart that lands exactly on the zero count separates "restart wins" from "expiry wins". The ignored inputs are checked against the output that would reveal them if they had taken effect: halt writes, zero-data control writes, period data values and snapshot captures.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      ADR_STATUS = 3'd0,
      ADR_CTRL   = 3'd1,
      ADR_PER_LO = 3'd2,
      ADR_PER_HI = 3'd3,
      ADR_SNP_LO = 3'd4,
      ADR_SNP_HI = 3'd5
   } wdt_addr_e;

   localparam int CTRL_GO_BIT   = 0;
   localparam int CTRL_HALT_BIT = 1;
   localparam int STAT_TO_BIT   = 0;
   localparam int STAT_RUN_BIT  = 1;

   typedef struct packed {
      logic go;
      logic restart;
      logic clr_flag;
      logic snap;
   } wdt_evt_t;
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
   import wdt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output wdt_evt_t          evt
);
   always_comb begin
      evt = '0;
      if (wr) begin
         case (addr)
            ADR_STATUS:             evt.clr_flag = 1'b1;
            ADR_CTRL:               evt.go       = wdata[CTRL_GO_BIT];
            ADR_PER_LO, ADR_PER_HI: evt.restart  = 1'b1;
            ADR_SNP_LO, ADR_SNP_HI: evt.snap     = 1'b1;
            default:                evt          = '0;
         endcase
      end
   end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
   parameter int          CNT_W = 32,
   parameter logic [CNT_W-1:0] LOAD  = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             go,
   input  logic             restart,
   input  logic             clr_flag,
   output logic             run_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             flag_q,
   output logic             req_q
);
   logic at_zero;
   logic expire;

   assign at_zero = (cnt_q == '0);
   assign expire  = run_q && at_zero && !restart;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         cnt_q  <= LOAD;
         flag_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         req_q <= expire;
         if (go)
            run_q <= 1'b1;
         if (restart)
            cnt_q <= LOAD;
         else if (run_q)
            cnt_q <= at_zero ? LOAD : cnt_q - 1'b1;
         if (expire)
            flag_q <= 1'b1;
         else if (clr_flag)
            flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/wdt_snap.sv
module wdt_snap #(
   parameter int CNT_W  = 32,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] snap_q
);
   generate
      if (ENABLE) begin : g_snap
         always_ff @(posedge clk) begin
            if (rst)
               snap_q <= '0;
            else if (take)
               snap_q <= cnt;
         end
      end else begin : g_nosnap
         logic unused_in;
         assign unused_in = ^{clk, rst, take, cnt};
         assign snap_q    = '0;
      end
   endgenerate
endmodule

// File: rtl/wdt_start_only.sv
module wdt_start_only
   import wdt_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int RELOAD_CLOCKS = 50_000_000,
   parameter bit HAS_SNAPSHOT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rst_req
);
   localparam int              CNT_W = 2 * DATA_W;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(RELOAD_CLOCKS - 1);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (RELOAD_CLOCKS >= 2) else $error("RELOAD_CLOCKS must be at least 2");
      assert (CNT_W >= 32 || RELOAD_CLOCKS <= (1 << CNT_W))
         else $error("RELOAD_CLOCKS does not fit the counter");
   end

   wdt_evt_t         evt;
   logic             go;
   logic             restart;
   logic             run_q;
   logic             flag_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] snap_q;

   wdt_decode #(.DATA_W(DATA_W)) u_dec (
      .wr    (wr),
      .addr  (addr),
      .wdata (wdata),
      .evt   (evt)
   );

   assign go      = evt.go;
   assign restart = evt.restart;

   wdt_core #(.CNT_W(CNT_W), .LOAD(LOAD)) u_core (
      .clk      (clk),
      .rst      (rst),
      .go       (go),
      .restart  (restart),
      .clr_flag (evt.clr_flag),
      .run_q    (run_q),
      .cnt_q    (cnt_q),
      .flag_q   (flag_q),
      .req_q    (rst_req)
   );

   wdt_snap #(.CNT_W(CNT_W), .ENABLE(HAS_SNAPSHOT)) u_snap (
      .clk    (clk),
      .rst    (rst),
      .take   (evt.snap),
      .cnt    (cnt_q),
      .snap_q (snap_q)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         ADR_STATUS: begin
            rdata[STAT_TO_BIT]  = flag_q;
            rdata[STAT_RUN_BIT] = run_q;
         end
         ADR_PER_LO: rdata = LOAD[DATA_W-1:0];
         ADR_PER_HI: rdata = LOAD[CNT_W-1:DATA_W];
         ADR_SNP_LO: rdata = snap_q[DATA_W-1:0];
         ADR_SNP_HI: rdata = snap_q[CNT_W-1:DATA_W];
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_start_only_chk.sv
module wdt_start_only_chk #(
   parameter int CNT_W = 32,
   parameter logic [CNT_W-1:0] LOAD = '1
) (
   input logic             clk,
   input logic             rst,
   input logic             rst_req,
   input logic             run_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             restart,
   input logic             go
);
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      rst_req |=> !rst_req); // R5
   AST_REQ_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
      $rose(rst_req) |-> ($past(run_q) && $past(cnt_q) == '0)); // R4
   AST_NEVER_HALTS: assert property (@(posedge clk) disable iff (rst)
      run_q |=> run_q); // R3
   AST_ARM_BY_GO: assert property (@(posedge clk) disable iff (rst)
      $rose(run_q) |-> $past(go)); // R2
   AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (rst)
      restart |=> (cnt_q == LOAD)); // R6
   AST_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
      (restart && cnt_q == '0) |=> !rst_req); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!run_q && !restart) |=> $stable(cnt_q)); // R1
endmodule

bind wdt_start_only wdt_start_only_chk #(.CNT_W(CNT_W), .LOAD(LOAD)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .rst_req (rst_req),
   .run_q   (run_q),
   .cnt_q   (cnt_q),
   .restart (restart),
   .go      (go)
);

// File: tb/wdt_start_only_test.sv
module wdt_start_only_test;
   localparam int TP  = 10;
   localparam int PER = 20;
   localparam int DW  = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr = 1'b0;
   logic [2:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rst_req;

   int n_run  = 0;
   int n_fail = 0;

   wdt_start_only #(.DATA_W(DW), .RELOAD_CLOCKS(PER), .HAS_SNAPSHOT(1'b1)) uut (
      .clk     (clk),
      .rst     (rst),
      .wr      (wr),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .rst_req (rst_req)
   );

   always #(TP/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1;
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic do_reset();
      rst = 1'b1; wr = 1'b0;
      tick(3);
      rst = 1'b0;
   endtask

   task automatic wait_pulse(input int limit, output int n);
      n = 0;
      do begin
         tick(1);
         n++;
      end while (!rst_req && n < limit);
   endtask

   task automatic t_reset();
      int v;
      int pulses;
      rst = 1'b1;
      tick(2);
      check(rst_req == 1'b0, "R1 req in reset", int'(rst_req), 0);
      do_reset();
      rd_reg(3'd0, v);
      check(v == 0, "R1 status after reset", v, 0);
      rd_reg(3'd4, v);
      check(v == 0, "R1 snapshot after reset", v, 0);
      pulses = 0;
      for (int i = 0; i < 3*PER; i++) begin
         tick(1);
         if (rst_req) pulses++;
      end
      check(pulses == 0, "R1 no request while idle", pulses, 0);
      wr_reg(3'd5, 16'h0);
      rd_reg(3'd4, v);
      check(v == PER-1, "R1 counter holds preload", v, PER-1);
   endtask

   task automatic t_idle_writes();
      int v;
      int pulses;
      do_reset();
      wr_reg(3'd1, 16'h0000);
      wr_reg(3'd1, 16'hFFFE);
      pulses = 0;
      for (int i = 0; i < 3*PER; i++) begin
         tick(1);
         if (rst_req) pulses++;
      end
      check(pulses == 0, "R2 zero go bit does not arm", pulses, 0);
      rd_reg(3'd0, v);
      check(v == 0, "R2 still stopped", v, 0);
      rd_reg(3'd1, v);
      check(v == 0, "R2 control reads zero", v, 0);
   endtask

   task automatic t_period();
      int v;
      int n;
      do_reset();
      wr_reg(3'd1, 16'h0001);
      rd_reg(3'd0, v);
      check(v == 2, "R2 running after go", v, 2);
      wait_pulse(5*PER, n);
      check(n == PER, "R4 first expiry edges", n, PER);
      tick(1);
      check(rst_req == 1'b0, "R5 request one clock", int'(rst_req), 0);
      rd_reg(3'd0, v);
      check(v == 3, "R9 timeout flag set", v, 3);
      wait_pulse(5*PER, n);
      check(n == PER-1, "R4 reload period", n, PER-1);
      wr_reg(3'd0, 16'h0000);
      rd_reg(3'd0, v);
      check(v == 2, "R9 flag cleared, run kept", v, 2);
   endtask

   task automatic t_halt();
      int v;
      int n;
      do_reset();
      wr_reg(3'd1, 16'h0001);
      tick(5);
      wr_reg(3'd1, 16'h0002);
      rd_reg(3'd0, v);
      check(v == 2, "R3 still running after halt", v, 2);
      wait_pulse(5*PER, n);
      check(n == PER-6, "R3 halt does not delay", n, PER-6);
   endtask

   task automatic t_restart();
      int v;
      int n;
      do_reset();
      wr_reg(3'd1, 16'h0001);
      tick(10);
      wr_reg(3'd2, 16'hFFFF);
      wait_pulse(5*PER, n);
      check(n == PER, "R6 restart via low address", n, PER);
      tick(3);
      wr_reg(3'd3, 16'h1234);
      wait_pulse(5*PER, n);
      check(n == PER, "R6 restart via high address", n, PER);
      rd_reg(3'd2, v);
      check(v == PER-1, "R7 period low readback", v, PER-1);
      rd_reg(3'd3, v);
      check(v == 0, "R7 period high readback", v, 0);
   endtask

   task automatic t_collide();
      int v;
      int n;
      do_reset();
      wr_reg(3'd1, 16'h0001);
      tick(PER-1);
      wr_reg(3'd2, 16'h0000);
      check(rst_req == 1'b0, "R8 restart beats zero", int'(rst_req), 0);
      rd_reg(3'd0, v);
      check(v == 2, "R8 flag stays clear", v, 2);
      wait_pulse(5*PER, n);
      check(n == PER, "R8 next expiry after restart", n, PER);
   endtask

   task automatic t_snapshot();
      int v;
      int n;
      do_reset();
      wr_reg(3'd1, 16'h0001);
      tick(4);
      wr_reg(3'd4, 16'hABCD);
      rd_reg(3'd4, v);
      check(v == PER-5, "R10 snapshot low", v, PER-5);
      rd_reg(3'd5, v);
      check(v == 0, "R10 snapshot high", v, 0);
      wait_pulse(5*PER, n);
      check(n == PER-5, "R10 capture does not disturb", n, PER-5);
   endtask

   initial begin
      #(TP * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_idle_writes();
      t_period();
      t_halt();
      t_restart();
      t_collide();
      t_snapshot();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule